// File: doc/BRIEF.md
# Triggered One-Shot Event Sequencer

This block plays back a fixed timetable of control-signal changes after a single trigger pulse. The timetable is a list of entries. Each entry names an output bit, the value it should take, and the number of clock cycles after the trigger at which that value must appear. The list is a constant in the shared package and is fixed when the design is elaborated. A counter starts when the trigger is seen, runs up to the largest offset in the list and then parks. Each output is a register that keeps its last assigned value between events. After the final entry has been applied the outputs never move again.

Typical uses are power-up or calibration sequences, where a few enables or strobes must be raised and dropped at known distances from a start event. All pins are plain control signals; there is no data stream and no handshake. The trigger is a level sampled on each rising edge. It only has an effect while the block is idle.

The shipped timetable drives two outputs. Output bit 0 goes high at offset 1, is written high again at offset 5, and goes low at offset 7. Output bit 1 goes high at offset 10 and low at offset 11. The last offset is therefore 11.

Top module: `tseq_top`

## Requirements
- R1: While `rst_i` is high at a rising edge, every bit of `ctrl_o` is 0 after that edge and the block is idle. This applies even in the middle of a run. After reset is released, no event fires until a new trigger arrives.
- R2: With `trig_i` held low, `ctrl_o` stays all zero for any number of cycles after reset.
- R3: If `trig_i` is high at rising edge T while the block is idle, an entry with offset k (k at least 1) is visible on `ctrl_o` right after edge T+k. Nothing changes at edge T itself.
- R4: The timetable gives `ctrl_o[0]` = 1 from offset 1 and 0 from offset 7. It gives `ctrl_o[1]` = 1 from offset 10 and 0 from offset 11.
- R5: Between scheduled events each output holds its last assigned value. For example, `ctrl_o[0]` reads 1 after edges T+1 through T+6.
- R6: An entry that writes the value an output already holds (bit 0 set to 1 at offset 5) leaves that output unchanged.
- R7: After edge T+11 no output changes again while the trigger stays low, and the counter stops.
- R8: A trigger that arrives while a run is in progress is ignored and does not restart or shift the timetable. This includes a trigger sampled at edge T+11, the edge that ends the run.
- R9: Once a run has ended, a new trigger starts a fresh run with the same timing as the first.
- R10: The cycle counter is sized from the largest offset in the timetable and never exceeds that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Start request, honoured only while idle |
| ctrl_o | output | N_OUT (2) | Scheduled control outputs, one register per bit |

## Verification
The bound checker watches the properties that hold on every cycle: reset clears the outputs, the outputs stay still while idle, the counter stays within its bound, and a busy counter advances by exactly one whatever the trigger does. Only the bench scenarios can show that each entry lands on its exact offset, that the redundant write at offset 5 causes no glitch, and that a run ends quietly. The same applies to a reset in mid-run and to a trigger placed on the very last busy cycle, which must be ignored. The bench compares a cycle-by-cycle expected output stream, built from the timetable, against the design.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  // Field widths of one timetable entry
  localparam int OFS_W = 8;
  localparam int N_OUT = 2;
  localparam int CH_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int N_EVT = 5;

  typedef struct packed {
    logic [OFS_W-1:0] ofs;  // cycles after trigger, must be >= 1
    logic [CH_W-1:0]  ch;   // output bit index
    logic             val;  // value written
  } evt_t;

  // Timetable: later entries win when offset and bit coincide
  localparam evt_t SCHED [N_EVT] = '{
    '{ofs: 8'd1,  ch: 1'd0, val: 1'b1},
    '{ofs: 8'd5,  ch: 1'd0, val: 1'b1},
    '{ofs: 8'd7,  ch: 1'd0, val: 1'b0},
    '{ofs: 8'd10, ch: 1'd1, val: 1'b1},
    '{ofs: 8'd11, ch: 1'd1, val: 1'b0}
  };

  function automatic int max_ofs();
    int m;
    m = 1;
    for (int i = 0; i < N_EVT; i++) begin
      if (int'(SCHED[i].ofs) > m) m = int'(SCHED[i].ofs);
    end
    return m;
  endfunction

  localparam int LAST_OFS = max_ofs();
  localparam int CNT_W    = $clog2(LAST_OFS + 1);

endpackage

// File: rtl/tseq_timer.sv
module tseq_timer
  import tseq_pkg::*;
#(
  parameter int LAST = LAST_OFS,
  parameter int CW   = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          trig_i,
  output logic [CW-1:0] cnt_o,
  output logic          run_o
);

  localparam logic [CW-1:0] LAST_C = CW'(LAST);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (trig_i) begin
        cnt_q <= CW'(1);
        run_q <= 1'b1;
      end
    end else if (cnt_q == LAST_C) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

endmodule

// File: rtl/tseq_match.sv
module tseq_match
  import tseq_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int CW = CNT_W
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          run_i,
  output logic [NE-1:0] hit_o
);

  logic [OFS_W-1:0] cnt_ext;
  assign cnt_ext = {{(OFS_W-CW){1'b0}}, cnt_i};

  for (genvar e = 0; e < NE; e++) begin : g_evt
    assign hit_o[e] = run_i && (cnt_ext == SCHED[e].ofs);
  end

endmodule

// File: rtl/tseq_outbank.sv
module tseq_outbank
  import tseq_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int NO = N_OUT
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [NE-1:0] hit_i,
  output logic [NO-1:0] q_o
);

  for (genvar c = 0; c < NO; c++) begin : g_out
    logic q_q, q_d;

    always_comb begin
      q_d = q_q;
      for (int e = 0; e < NE; e++) begin
        if (hit_i[e] && (SCHED[e].ch == CH_W'(c))) q_d = SCHED[e].val;
      end
    end

    always_ff @(posedge clk_i) begin
      if (rst_i) q_q <= 1'b0;
      else       q_q <= q_d;
    end

    assign q_o[c] = q_q;
  end

endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int NO = N_OUT
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          trig_i,
  output logic [NO-1:0] ctrl_o
);

  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [N_EVT-1:0] hit;

  tseq_timer #(.LAST(LAST_OFS), .CW(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .trig_i(trig_i),
    .cnt_o (cnt),
    .run_o (running)
  );

  tseq_match #(.NE(N_EVT), .CW(CNT_W)) u_match (
    .cnt_i(cnt),
    .run_i(running),
    .hit_o(hit)
  );

  tseq_outbank #(.NE(N_EVT), .NO(NO)) u_out (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .hit_i(hit),
    .q_o  (ctrl_o)
  );

endmodule

// File: rtl/tseq_chk.sv
module tseq_chk
  import tseq_pkg::*;
#(
  parameter int NO = N_OUT
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             trig_i,
  input logic [NO-1:0]    ctrl_o,
  input logic [CNT_W-1:0] cnt,
  input logic             running
);

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (ctrl_o == '0) && !running);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !running |=> $stable(ctrl_o));

  assert_stay_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!running && !trig_i) |=> !running);

  assert_busy_advance_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (running && (int'(cnt) != LAST_OFS)) |=> running && (cnt == $past(cnt) + CNT_W'(1)));

  assert_run_ends_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (running && (int'(cnt) == LAST_OFS)) |=> !running);

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(cnt) <= LAST_OFS);

endmodule

bind tseq_top tseq_chk #(.NO(NO)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .trig_i (trig_i),
  .ctrl_o (ctrl_o),
  .cnt    (cnt),
  .running(running)
);

// File: tb/tseq_top_tb.sv
`timescale 1ns/1ps
module tseq_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic [1:0] ctrl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tseq_top u_dut (
    .clk_i (clk_i_w),
    .rst_i (rst),
    .trig_i(trig),
    .ctrl_o(ctrl)
  );

  wire clk_i_w = clk;

  // Expected outputs k cycles after the trigger edge (bit0 = A, bit1 = B)
  function automatic logic [1:0] model(int k);
    logic a, b;
    a = (k >= 1) && (k < 7);
    b = (k == 10);
    return {b, a};
  endfunction

  function automatic string tag_for(int k);
    if (k <= 1) return "R3";
    if (k == 5) return "R6";
    if (k == 7 || k == 10 || k == 11) return "R4";
    if (k > 11) return "R7";
    return "R5";
  endfunction

  task automatic check(logic [1:0] act, logic [1:0] exp, string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_run(int upto, string over);
    for (int k = 0; k <= upto; k++) begin
      exp_q.push_back(model(k));
      tag_q.push_back(over == "" ? tag_for(k) : over);
    end
  endtask

  task automatic push_zero(int n, string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(2'b00);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic pulse();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  // Monitor: compares one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) check(ctrl, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(ctrl, 2'b00, "R1");
    rst = 1'b0;
    @(negedge clk);
    push_zero(100, "R2");
    drain();

    // Basic run, then a long quiet tail
    @(negedge clk);
    pulse();
    push_run(40, "");
    drain();

    // Retrigger mid-run and on the final busy cycle (edge T+11)
    @(negedge clk);
    pulse();
    push_run(30, "R8");
    repeat (3) @(negedge clk);
    pulse();
    repeat (6) @(negedge clk);
    pulse();
    drain();

    // Fresh run after completion
    @(negedge clk);
    pulse();
    push_run(20, "R9");
    drain();

    // Reset in the middle of a run
    @(negedge clk);
    pulse();
    repeat (3) @(negedge clk);
    #1 check(ctrl, 2'b01, "R1");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1 check(ctrl, 2'b00, "R1");
    rst = 1'b0;
    @(negedge clk);
    push_zero(30, "R1");
    drain();

    // Counter must still work after the reset
    @(negedge clk);
    pulse();
    push_run(15, "R10");
    drain();

    done = 1;
    finish_run();
  end

endmodule